// File: doc/BRIEF.md
# Noise Channel LFSR Generator

This block generates the pseudo-random noise source for a sound channel. A write port loads one control byte. Its low nibble is a rate index, and its top bit picks one of two sequence lengths. The rate index is looked up in a fixed sixteen-entry table to give an 11-bit reload value for a down-counting timer.

Every second expiry of the timer advances a 15-bit linear feedback shift register by one step. The register's top bit, inverted, is the noise bit. The noise bit gates a 4-bit volume supplied from outside, and the gated value is the channel sample. A channel-active flag, also supplied from outside, mutes the sample. Envelope and length counting live elsewhere and reach this block only through those two inputs.

Both outputs are registered, so they follow the shift register state with one clock of latency.

Top module: `noise_lfsr_gen`

## Requirements
- R1: On a clock with `wr_en` high, `wr_data[3:0]` becomes the rate index and `wr_data[7]` becomes the mode (0 = long, 1 = short). Bits 6 to 4 have no effect on any output. Both fields hold their value between writes, and both reset to 0.
- R2: For rate index i, the timer expires once every C(i) clocks. C for indices 0 to 15 is 2, 4, 8, 16, 32, 48, 64, 80, 101, 127, 190, 254, 381, 508, 1017, 2034. The timer counts down to zero and reloads with C(i)-1 on the clock when it is zero.
- R3: A new rate index does not disturb a count in progress. It is used from the next reload onward.
- R4: A shift moves every register bit one place toward bit 14 and loads the feedback into bit 0. In long mode the feedback is bit 14 XOR bit 13.
- R5: In short mode the feedback is bit 14 XOR bit 8.
- R6: The register shifts on every second timer expiry and holds its value at all other times. The first expiry after reset does not shift; the second one does.
- R7: `noise_bit` is the inverse of register bit 14, delayed by one clock.
- R8: While reset is high, the register holds 1, the timer count is 0, and both outputs are 0. The first timer expiry comes on the first clock after reset is released.
- R9: `sample` equals the `volume` and `chan_active` of the previous clock when the noise bit is high and the channel was active. Otherwise `sample` is 0.
- R10: Starting from the reset state in long mode, the noise bit stream repeats every 32767 shifts.
- R11: Starting from the reset state in short mode, the noise bit stream repeats every 93 shifts and does not repeat every 31 or every 3 shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte: rate index in bits 3:0, mode in bit 7 |
| volume | input | 4 | Volume level from the external envelope |
| chan_active | input | 1 | Channel enabled by the external length logic |
| noise_bit | output | 1 | Registered noise bit |
| sample | output | 4 | Registered gated sample |

## Verification
The assertions check the local invariants on every cycle:
- the down-count and reload of the timer;
- the hold and one-place shift of the register, and that it never becomes zero;
- that the control fields are stable between writes;
- that a non-zero sample is seen only with the noise bit high.

Other behaviours show up only over long scenarios, so the bench covers them:
- the exact period for each of the sixteen rate indices;
- when a changed index takes effect;
- the feedback taps of each mode;
- the full 32767-step and 93-step sequence lengths.

The bench checks these against a model that runs in step with the design.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int RATE_IDX_W = 4;
  localparam int PERIOD_W   = 11;

  typedef logic [RATE_IDX_W-1:0] rate_idx_t;
  typedef logic [PERIOD_W-1:0]   period_t;

  // Reload value (clocks per expiry minus one) for each rate index.
  function automatic period_t reload_of(input rate_idx_t idx);
    period_t r;
    case (idx)
      4'h0: r = 11'h001;
      4'h1: r = 11'h003;
      4'h2: r = 11'h007;
      4'h3: r = 11'h00F;
      4'h4: r = 11'h01F;
      4'h5: r = 11'h02F;
      4'h6: r = 11'h03F;
      4'h7: r = 11'h04F;
      4'h8: r = 11'h064;
      4'h9: r = 11'h07E;
      4'hA: r = 11'h0BD;
      4'hB: r = 11'h0FD;
      4'hC: r = 11'h17C;
      4'hD: r = 11'h1FB;
      4'hE: r = 11'h3F8;
      default: r = 11'h7F1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/noise_rate_reg.sv
module noise_rate_reg
  import noise_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int MODE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output rate_idx_t         idx_q,
  output logic              short_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      short_q <= 1'b0;
    end else if (wr_en) begin
      idx_q   <= wr_data[RATE_IDX_W-1:0];
      short_q <= wr_data[MODE_BIT];
    end
  end

  // R1: fields hold between writes
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(idx_q) && $stable(short_q)));
  // R1: reserved bits do not alter the captured index
  p_rsvd_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_data[MODE_BIT-1:RATE_IDX_W] != '0))
      |=> (idx_q == $past(wr_data[RATE_IDX_W-1:0])));
endmodule

// File: rtl/noise_period_timer.sv
module noise_period_timer
  import noise_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  period_t reload_val,
  output logic    expire
);
  period_t cnt;

  assign expire = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (expire) cnt <= reload_val;
    else             cnt <= cnt - 1'b1;
  end

  // R2: counts down by one while non-zero
  p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  // R3: reload picks the value presented at the expiry clock
  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> (cnt == $past(reload_val)));
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int LFSR_W    = 15,
  parameter int TAP_LONG  = 13,
  parameter int TAP_SHORT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic short_mode,
  output logic msb
);
  localparam int TOP = LFSR_W - 1;

  logic [LFSR_W-1:0] sr;
  logic              half;
  logic              shift_en;
  logic              fb;

  assign shift_en = step && half;
  assign fb       = sr[TOP] ^ (short_mode ? sr[TAP_SHORT] : sr[TAP_LONG]);
  assign msb      = sr[TOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= {{(LFSR_W-1){1'b0}}, 1'b1};
      half <= 1'b0;
    end else begin
      if (step)     half <= ~half;
      if (shift_en) sr   <= {sr[TOP-1:0], fb};
    end
  end

  // R8: register never reaches the all-zero lock state
  p_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    sr != '0);
  // R6: register holds unless the second expiry arrives
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr));
  // R6: first expiry of a pair never shifts
  p_first_half_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !half) |=> $stable(sr));
  // R4: shift moves bits toward the top
  p_shift_dir_r4: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (sr[TOP:1] == $past(sr[TOP-1:0])));
endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
  import noise_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MODE_BIT  = 7,
  parameter int VOL_W     = 4,
  parameter int LFSR_W    = 15,
  parameter int TAP_LONG  = 13,
  parameter int TAP_SHORT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [VOL_W-1:0]  volume,
  input  logic              chan_active,
  output logic              noise_bit,
  output logic [VOL_W-1:0]  sample
);
  rate_idx_t idx_q;
  logic      short_q;
  logic      expire;
  logic      msb;
  period_t   reload_val;

  noise_rate_reg #(.BYTE_W(BYTE_W), .MODE_BIT(MODE_BIT)) u_rate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .idx_q(idx_q), .short_q(short_q)
  );

  assign reload_val = reload_of(idx_q);

  noise_period_timer u_timer (
    .clk(clk), .rst(rst), .reload_val(reload_val), .expire(expire)
  );

  noise_lfsr #(.LFSR_W(LFSR_W), .TAP_LONG(TAP_LONG), .TAP_SHORT(TAP_SHORT)) u_lfsr (
    .clk(clk), .rst(rst), .step(expire), .short_mode(short_q), .msb(msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      noise_bit <= 1'b0;
      sample    <= '0;
    end else begin
      noise_bit <= ~msb;
      sample    <= (~msb && chan_active) ? volume : '0;
    end
  end

  // R9: a non-zero sample implies the noise bit is high
  p_sample_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (sample != '0) |-> noise_bit);
  // R9: an inactive channel is muted on the next clock
  p_inactive_mute_r9: assert property (@(posedge clk) disable iff (rst)
    !chan_active |=> (sample == '0));
  // R7: noise bit follows the inverted top bit one clock later
  p_bit_follow_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (noise_bit == !$past(msb)));
endmodule

// File: tb/sim_noise_lfsr_gen.sv
module sim_noise_lfsr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_P     = 32767;
  localparam int SHORT_P    = 93;
  localparam int WIN        = 40;
  localparam int WATCHDOG   = 195000;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [3:0] volume;
  logic       chan_active;
  logic       noise_bit;
  logic [3:0] sample;

  noise_lfsr_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .volume(volume), .chan_active(chan_active),
    .noise_bit(noise_bit), .sample(sample)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int clk_tbl [16] = '{2, 4, 8, 16, 32, 48, 64, 80,
                       101, 127, 190, 254, 381, 508, 1017, 2034};

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  // Lock-step model built from the requirements
  int         m_cnt;
  bit         m_half;
  bit [14:0]  m_sr;
  bit [3:0]   m_idx;
  bit         m_mode;
  bit         exp_bit;
  bit [3:0]   exp_samp;
  int         sc, sc_q;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_half <= 0; m_sr <= 15'd1; m_idx <= 0; m_mode <= 0;
      exp_bit <= 0; exp_samp <= 0; sc <= 0; sc_q <= 0;
    end else begin
      if (wr_en) begin
        m_idx  <= wr_data[3:0];
        m_mode <= wr_data[7];
      end
      if (m_cnt == 0) begin
        m_cnt  <= clk_tbl[m_idx] - 1;
        m_half <= ~m_half;
        if (m_half) begin
          m_sr <= {m_sr[13:0], m_sr[14] ^ (m_mode ? m_sr[8] : m_sr[13])};
          sc   <= sc + 1;
        end
      end else begin
        m_cnt <= m_cnt - 1;
      end
      exp_bit  <= ~m_sr[14];
      exp_samp <= (~m_sr[14] && chan_active) ? volume : 4'd0;
      sc_q     <= sc;
    end
  end

  bit cmp_on = 0;
  int mism_bit = 0, mism_samp = 0, per_mism = 0;
  bit bits_a [0:255];

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      if (noise_bit !== exp_bit) mism_bit++;
      if (sample !== exp_samp)   mism_samp++;
      if (sc_q < 256) bits_a[sc_q] = noise_bit;
      if (sc_q >= LONG_P && sc_q < LONG_P + WIN)
        if (noise_bit !== bits_a[sc_q - LONG_P]) per_mism++;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    volume      = 4'(cyc ^ (cyc >> 4));
    chan_active = ((cyc >> 2) & 1) == 1;
    wr_en       = 1'b0;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic restart(input logic [7:0] d);
    cmp_on = 0;
    rst = 1'b1; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; wr_en = 1'b1; wr_data = d;
    mism_bit = 0; mism_samp = 0; per_mism = 0;
    cmp_on = 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00; volume = 4'hF; chan_active = 1'b1;
    repeat (3) @(negedge clk);
    // R8: reset state at the ports
    chk(noise_bit == 1'b0, "R8 noise_bit in reset", noise_bit, 0);
    chk(sample == 4'd0, "R8 sample in reset", sample, 0);
    rst = 1'b0; chan_active = 1'b0;
    @(negedge clk);
    // R7 R8: register holds 1, so bit 14 is 0 and noise bit is 1
    chk(noise_bit == 1'b1, "R7 R8 first noise bit", noise_bit, 1);
    chk(sample == 4'd0, "R9 inactive sample", sample, 0);

    restart(8'h00);
    // R2 R1: sweep every rate index, with junk in bits 6..4
    for (int i = 0; i < 16; i++) begin
      mism_bit = 0;
      do_write({1'b0, 3'(i + 1), 4'(i)});
      run(4 * clk_tbl[i] + 4);
      chk(mism_bit == 0, $sformatf("R2 R1 index %0d bit mismatches", i), mism_bit, 0);
    end
    // R9: sample gating across the sweep
    chk(mism_samp == 0, "R9 sample mismatches", mism_samp, 0);

    // R3: change index in the middle of a long count
    mism_bit = 0;
    do_write(8'h0F);
    run(2200);
    do_write(8'h00);
    run(1500);
    do_write(8'h83);
    run(300);
    chk(mism_bit == 0, "R3 R5 mid-count index change", mism_bit, 0);

    // R10 R4: full long-mode period
    restart(8'h70);
    while (sc_q < LONG_P + WIN) tick();
    chk(mism_bit == 0, "R4 long mode bit stream", mism_bit, 0);
    chk(per_mism == 0, "R10 repeat after 32767 shifts", per_mism, 0);

    // R11 R5: short-mode period
    restart(8'hF0);
    while (sc_q < 200) tick();
    tick();
    chk(mism_bit == 0, "R5 short mode bit stream", mism_bit, 0);
    begin
      int d93 = 0, d31 = 0, d3 = 0;
      for (int k = 0; k < 100; k++) begin
        if (bits_a[k] != bits_a[k + SHORT_P]) d93++;
        if (bits_a[k] != bits_a[k + 31]) d31++;
        if (bits_a[k] != bits_a[k + 3]) d3++;
      end
      chk(d93 == 0, "R11 repeat after 93 shifts", d93, 0);
      chk(d31 != 0, "R11 no repeat after 31 shifts", d31, 1);
      chk(d3 != 0, "R11 no repeat after 3 shifts", d3, 1);
    end

    done = 1;
    summary();
  end
endmodule